// File: doc/BRIEF.md
# Multi-slot Ethernet receive buffer writer

This block takes a received frame stream, one beat per valid cycle, and stores each frame into one of `NSLOT` fixed-size memory slots. Each slot holds `SLOT_WORDS` beats. When a frame ends cleanly, the block records the slot index, the stored length and a truncation flag in a completion queue, which a CPU drains through a pop strobe. Once the CPU has finished with a slot, it hands the slot back with a release strobe.

The block keeps a count of free slots. A frame may be written only if at least one slot is free on its first beat. A frame that arrives with no free slot is consumed without touching memory. Such a frame never produces a queue entry and never moves the slot pointer, so the CPU is never given a slot that was written twice or that it is still reading.

Frames longer than a slot are cut to the slot size, and the cut is flagged in the entry. A frame that ends with an error indication is discarded, and its slot is written again by the next frame. Two saturating counters record how many frames were dropped for lack of space and how many were discarded for an error.

Top module: `rxw_slot_writer`

## Requirements
- R1: After reset the completion queue is empty (`cq_valid` low), both counters read zero, `mem_we` is low with no input, and all `NSLOT` slots are free.
- R2: The k-th beat (k from 0) of an accepted frame is written, in the same cycle as the beat, with `mem_we` high, `mem_addr` = slot × `SLOT_WORDS` + k and `mem_wdata` = the beat data, for k < `SLOT_WORDS`.
- R3: A frame that ends without error adds one queue entry, visible in the cycle after its last beat. The entry's `cq_slot` is the slot that was written and its `cq_len` is the number of beats stored. The slot pointer then advances by one, wrapping from `NSLOT`-1 to 0.
- R4: Beats of a frame beyond `SLOT_WORDS` are not written. The entry for such a frame has `cq_len` = `SLOT_WORDS` and `cq_trunc` = 1; a frame that fits has `cq_trunc` = 0.
- R5: A frame whose last beat carries `in_err` adds no queue entry and increments `err_count`. Its slot is written again by the next frame.
- R6: A frame that begins while no slot is free writes no beat, adds no queue entry, leaves the slot pointer where it was, and increments `drop_count` exactly once.
- R7: A release strobe that arrives while a dropped frame is being consumed does not create an entry for that frame. The freed slot is taken by the next frame.
- R8: Each release strobe returns one slot. A release while all slots are already free is ignored, so no more than `NSLOT` frames can ever be accepted without releases.
- R9: `drop_count` and `err_count` each stop at 2^`CNT_W`-1.
- R10: Queue entries leave in the order they were committed. `cq_pop` removes the head entry, and a pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A beat is present on the stream |
| in_data | input | DATA_W | Beat data |
| in_last | input | 1 | Beat is the last of its frame |
| in_err | input | 1 | Frame is bad; sampled with `in_last` |
| mem_we | output | 1 | Slot memory write enable |
| mem_addr | output | $clog2(NSLOT*SLOT_WORDS) | Slot memory write address |
| mem_wdata | output | DATA_W | Slot memory write data |
| cq_valid | output | 1 | The completion queue holds an entry |
| cq_slot | output | $clog2(NSLOT) | Slot index of the head entry |
| cq_len | output | $clog2(SLOT_WORDS+1) | Stored beat count of the head entry |
| cq_trunc | output | 1 | The head entry's frame was cut to fit |
| cq_pop | input | 1 | Remove the head entry |
| rel_strobe | input | 1 | The CPU returns one slot |
| drop_count | output | CNT_W | Frames dropped for lack of a slot, saturating |
| err_count | output | CNT_W | Frames discarded for an error, saturating |

## Verification
The assertions check the following rules on every cycle:
- the free count never goes above `NSLOT`, and a slot is never taken while the count is zero;
- the queue never receives a push while it is full;
- a push always advances the slot pointer, and the pointer holds still otherwise;
- no memory write happens while a dropped frame is being consumed;
- write addresses stay inside the current slot;
- stored lengths stay in range, and the counters hold at their maximum.

Only the bench scenarios can show the behaviour that depends on frame history. This covers the exact entry contents after lengths around the slot size, and reuse of a slot after an error frame. It also covers the effect of a release that arrives in the middle of a dropped frame, release strobes that are ignored, and the order in which entries come out after the slots wrap.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_FILL = 2'd1,
    WR_SKIP = 2'd2
  } wr_state_e;

  // Next index in a ring of n positions.
  function automatic int wrap_inc(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // First address of a slot.
  function automatic int slot_base(int slot, int words);
    return slot * words;
  endfunction

  // Stored length for a frame of the given beat count.
  function automatic int clip_len(int beats, int cap);
    return (beats > cap) ? cap : beats;
  endfunction

endpackage

// File: rtl/rxw_sat_ctr.sv
module rxw_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == MAXV);
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (inc && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV)); // R9
  AST_SAT_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc) |=> $stable(count)); // R9

endmodule

// File: rtl/rxw_free_ctr.sv
module rxw_free_ctr #(
  parameter int NSLOT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic have_free
);
  localparam int FW = $clog2(NSLOT + 1);

  logic [FW-1:0] free_q;
  logic          give_ok;

  assign give_ok   = give && (free_q < FW'(NSLOT));
  assign have_free = (free_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= FW'(NSLOT);
    else begin
      case ({give_ok, take})
        2'b10:   free_q <= free_q + 1'b1;
        2'b01:   free_q <= free_q - 1'b1;
        default: free_q <= free_q;
      endcase
    end
  end

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= FW'(NSLOT)); // R8
  AST_TAKE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (free_q != '0)); // R6

endmodule

// File: rtl/rxw_cpl_fifo.sv
module rxw_cpl_fifo
  import rxw_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic                       valid,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign pop_ok = pop && (cnt_q != '0);
  assign valid  = (cnt_q != '0);
  assign dout   = mem_q[rd_q];
  assign level  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q        <= PW'(wrap_inc(int'(wr_q), DEPTH));
      end
      if (pop_ok) rd_q <= PW'(wrap_inc(int'(rd_q), DEPTH));
      case ({push, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((cnt_q < CW'(DEPTH)) || pop_ok)); // R3
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/rxw_slot_writer.sv
module rxw_slot_writer
  import rxw_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter int SLOT_WORDS = 256,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [DATA_W-1:0]                 in_data,
  input  logic                              in_last,
  input  logic                              in_err,
  output logic                              mem_we,
  output logic [$clog2(NSLOT*SLOT_WORDS)-1:0] mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  output logic                              cq_valid,
  output logic [$clog2(NSLOT)-1:0]          cq_slot,
  output logic [$clog2(SLOT_WORDS+1)-1:0]   cq_len,
  output logic                              cq_trunc,
  input  logic                              cq_pop,
  input  logic                              rel_strobe,
  output logic [CNT_W-1:0]                  drop_count,
  output logic [CNT_W-1:0]                  err_count
);
  localparam int ADDR_W = $clog2(NSLOT * SLOT_WORDS);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int OFF_W  = $clog2(SLOT_WORDS + 1);
  localparam int ENT_W  = 1 + OFF_W + SLOT_W;
  localparam logic [OFF_W-1:0] CAP = OFF_W'(SLOT_WORDS);

  wr_state_e         state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic [OFF_W-1:0]  off_q;
  logic              trunc_q;

  // Named events, shared by the logic and the assertions.
  logic              have_free;
  logic              frame_start, accept_start, drop_start;
  logic              fill_beat, fill_room, beat_kept;
  logic              frame_end, commit_evt, err_evt;
  logic [OFF_W-1:0]  beat_off, len_now;
  logic              trunc_now;
  logic [ENT_W-1:0]  ent_in, ent_out;
  logic [$clog2(NSLOT+1)-1:0] cq_level;

  assign frame_start  = in_valid && (state_q == WR_IDLE);
  assign accept_start = frame_start && have_free;
  assign drop_start   = frame_start && !have_free;
  assign fill_beat    = in_valid && (state_q == WR_FILL);
  assign fill_room    = (off_q < CAP);
  assign beat_kept    = accept_start || (fill_beat && fill_room);
  assign frame_end    = (accept_start || fill_beat) && in_last;
  assign commit_evt   = frame_end && !in_err;
  assign err_evt      = frame_end && in_err;

  assign beat_off  = (state_q == WR_IDLE) ? '0 : off_q;
  assign len_now   = beat_kept ? (beat_off + 1'b1) : CAP;
  assign trunc_now = (state_q == WR_FILL) && (trunc_q || !fill_room);

  assign mem_we    = beat_kept;
  assign mem_addr  = ADDR_W'(slot_base(int'(slot_q), SLOT_WORDS) + int'(beat_off));
  assign mem_wdata = in_data;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WR_IDLE: begin
        if (accept_start && !in_last)    state_d = WR_FILL;
        else if (drop_start && !in_last) state_d = WR_SKIP;
      end
      WR_FILL: if (fill_beat && in_last) state_d = WR_IDLE;
      WR_SKIP: if (in_valid && in_last)  state_d = WR_IDLE;
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      slot_q  <= '0;
      off_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_start) begin
        off_q   <= OFF_W'(1);
        trunc_q <= 1'b0;
      end else if (fill_beat) begin
        if (fill_room) off_q   <= off_q + 1'b1;
        else           trunc_q <= 1'b1;
      end
      if (commit_evt) slot_q <= SLOT_W'(wrap_inc(int'(slot_q), NSLOT));
    end
  end

  rxw_free_ctr #(.NSLOT(NSLOT)) u_free (
    .clk(clk), .rst_n(rst_n),
    .take(commit_evt), .give(rel_strobe),
    .have_free(have_free)
  );

  assign ent_in = {trunc_now, len_now, slot_q};

  rxw_cpl_fifo #(.W(ENT_W), .DEPTH(NSLOT)) u_cq (
    .clk(clk), .rst_n(rst_n),
    .push(commit_evt), .din(ent_in),
    .pop(cq_pop), .valid(cq_valid), .dout(ent_out), .level(cq_level)
  );

  assign cq_slot  = ent_out[SLOT_W-1:0];
  assign cq_len   = ent_out[SLOT_W +: OFF_W];
  assign cq_trunc = ent_out[ENT_W-1];

  rxw_sat_ctr #(.W(CNT_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop_start), .count(drop_count)
  );
  rxw_sat_ctr #(.W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc(err_evt), .count(err_count)
  );

  AST_ADDR_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_addr) / SLOT_WORDS == int'(slot_q))); // R2
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (int'(slot_q) == wrap_inc(int'($past(slot_q)), NSLOT))); // R3
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(slot_q)); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (len_now != '0 && len_now <= CAP)); // R4
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WR_SKIP) |-> !mem_we); // R6
  AST_SKIP_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WR_SKIP) |=> (cq_level <= $past(cq_level))); // R7
  AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && in_err) |=> (cq_level <= $past(cq_level))); // R5

endmodule

// File: tb/rxw_slot_writer_test.sv
module rxw_slot_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SW = 4;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic cq_pop = 1'b0, rel_strobe = 1'b0;
  logic mem_we, cq_valid, cq_trunc;
  logic [$clog2(NS*SW)-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [$clog2(NS)-1:0] cq_slot;
  logic [$clog2(SW+1)-1:0] cq_len;
  logic [CW-1:0] drop_count, err_count;

  rxw_slot_writer #(.NSLOT(NS), .SLOT_WORDS(SW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cq_valid(cq_valid), .cq_slot(cq_slot), .cq_len(cq_len), .cq_trunc(cq_trunc),
    .cq_pop(cq_pop), .rel_strobe(rel_strobe),
    .drop_count(drop_count), .err_count(err_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_free = NS, m_slot = 0, m_drop = 0, m_err = 0;
  int q_slot [16], q_len [16], q_tr [16];
  int q_n = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    chk({req, " drop_count"}, int'(drop_count), m_drop);
    chk({req, " err_count"}, int'(err_count), m_err);
    chk({req, " cq_valid"}, int'(cq_valid), (q_n > 0) ? 1 : 0);
    if (q_n > 0) begin
      chk({req, " cq_slot"}, int'(cq_slot), q_slot[0]);
      chk({req, " cq_len"}, int'(cq_len), q_len[0]);
      chk({req, " cq_trunc"}, int'(cq_trunc), q_tr[0]);
    end
  endtask

  // One frame of n beats; rel_at picks a beat that also carries a release.
  task automatic send_frame(int n, bit err, int rel_at, int fid);
    bit acc;
    acc = (m_free > 0);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid   = 1'b1;
      in_data    = DW'(fid * 16 + k);
      in_last    = (k == n - 1);
      in_err     = err && (k == n - 1);
      rel_strobe = (k == rel_at);
      @(negedge clk);
      if (acc && k < SW) begin
        chk("R2 mem_we", int'(mem_we), 1);
        chk("R2 mem_addr", int'(mem_addr), m_slot * SW + k);
        chk("R2 mem_wdata", int'(mem_wdata), (fid * 16 + k) % 256);
      end else begin
        chk(acc ? "R4 mem_we beyond slot" : "R6 mem_we on dropped frame", int'(mem_we), 0);
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; rel_strobe = 1'b0;
    if (!acc) begin
      if (m_drop < SAT) m_drop++;
    end else if (err) begin
      if (m_err < SAT) m_err++;
    end else begin
      q_slot[q_n] = m_slot;
      q_len[q_n]  = (n > SW) ? SW : n;
      q_tr[q_n]   = (n > SW) ? 1 : 0;
      q_n++;
      m_slot = (m_slot + 1) % NS;
      m_free--;
    end
    if (rel_at >= 0 && rel_at < n && m_free < NS) m_free++;
    @(negedge clk);
    check_status(acc ? (err ? "R5" : "R3") : "R6");
  endtask

  task automatic pop_one();
    @(posedge clk); #1 cq_pop = 1'b1;
    @(posedge clk); #1 cq_pop = 1'b0;
    if (q_n > 0) begin
      for (int i = 0; i < q_n - 1; i++) begin
        q_slot[i] = q_slot[i+1]; q_len[i] = q_len[i+1]; q_tr[i] = q_tr[i+1];
      end
      q_n--;
    end
    @(negedge clk);
    check_status("R10");
  endtask

  task automatic release_one();
    @(posedge clk); #1 rel_strobe = 1'b1;
    @(posedge clk); #1 rel_strobe = 1'b0;
    if (m_free < NS) m_free++;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int fid;
    fid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 cq_valid", int'(cq_valid), 0);
    chk("R1 drop_count", int'(drop_count), 0);
    chk("R1 err_count", int'(err_count), 0);
    chk("R1 mem_we", int'(mem_we), 0);

    // R10: pop on empty queue has no effect
    pop_one();

    // R8: releases while every slot is free are ignored
    release_one();
    release_one();

    // R2 R3 R4 R5: sweep lengths around the slot size, good and bad
    for (int n = 1; n <= SW + 2; n++) begin
      for (int e = 0; e < 2; e++) begin
        send_frame(n, e[0], -1, fid++);
        if (e == 0) begin pop_one(); release_one(); end
      end
    end

    // R6 R8: fill every slot; the next frame is dropped
    for (int i = 0; i < NS; i++) send_frame(2, 1'b0, -1, fid++);
    send_frame(3, 1'b0, -1, fid++);
    send_frame(1, 1'b0, -1, fid++);

    // R7: release mid-drop yields no entry; next frame takes the slot
    pop_one();
    send_frame(3, 1'b0, 1, fid++);
    send_frame(2, 1'b0, -1, fid++);
    for (int i = 0; i < NS; i++) begin pop_one(); release_one(); end

    // R9: saturate drop counter
    for (int i = 0; i < NS; i++) send_frame(1, 1'b0, -1, fid++);
    for (int i = 0; i < SAT + 4; i++) send_frame(1, 1'b0, -1, fid++);
    for (int i = 0; i < NS; i++) begin pop_one(); release_one(); end

    // R9: saturate error counter; R5 slot reuse seen on the next frame
    for (int i = 0; i < SAT + 4; i++) send_frame(2, 1'b1, -1, fid++);
    send_frame(3, 1'b0, -1, fid++);
    pop_one();

    done = 1;
    summary();
    $finish;
  end

endmodule